// File: doc/BRIEF.md
# Table-Driven DMA Channel Scheduler

This block decides which DMA channel, and in which direction, gets the next service slot. Software loads a slot table, packed four 8-bit entries to a 32-bit word, and a control word holding an enable flag and the index of the last valid entry. Once enabled, the scheduler reads entries in order from index 0 up to the last index, then returns to 0 and repeats. Each entry names a channel and whether the slot is a receive or a transmit slot.

For every entry the scheduler presents the channel number and direction on the channel side and holds them until that side answers with a one-cycle done or skip pulse. A channel that has no work answers with skip, and the walk moves on exactly as for done. Clearing the enable flag stops the walk at once. The table is left intact, so setting the flag again restarts service from entry 0 with the same table.

Top module: `dma_slot_sched`

## Requirements
- R1: After a synchronous reset, slot_valid is 0, the control word reads back as 0 and reg_rdata is 0.
- R2: The control word sits at byte offset 0, with enable at bit 31 and the last entry index in the low IDX_W bits. Table word w sits at byte offset 0x800 + 4*w. A read strobe returns the stored value on reg_rdata in the following cycle.
- R3: Entry k of a table word occupies bits [8k+7:8k]. Entry index i lives in word i/4 at entry position i%4. Within an entry, bits [6:0] give slot_chan and bit 7 gives slot_rx: 1 means receive and 0 means transmit.
- R4: While enabled, entries are presented in the order 0, 1, ..., last, 0, 1, ... The entry that follows the last index is always entry 0.
- R5: A presented slot keeps slot_valid, slot_chan and slot_rx unchanged until a done or skip pulse is sampled.
- R6: A done pulse and a skip pulse both end the slot. slot_valid is 0 in the two cycles after the pulse edge and is 1 with the next entry on the third edge.
- R7: Writing the control word with enable clear drops slot_valid no later than the second edge after the write. The table contents are preserved.
- R8: Each time enable changes from 0 to 1, the walk starts again from entry 0.
- R9: A control write that keeps enable set does not restart the walk or disturb the slot being held. Its new last index governs every later wrap decision.
- R10: A table word written while the scheduler runs supplies the entries read the next time those entries are visited.
- R11: Done or skip pulses while slot_valid is 0 have no effect on the walk.
- R12: The first slot after enabling appears on the third clock edge after the edge that takes the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle after reg_rd |
| slot_valid | output | 1 | A slot is being presented |
| slot_chan | output | 7 | Channel number of the presented slot |
| slot_rx | output | 1 | 1 for a receive slot, 0 for a transmit slot |
| slot_done | input | 1 | One-cycle pulse: slot serviced |
| slot_skip | input | 1 | One-cycle pulse: channel not ready, slot skipped |

## Verification
The bench goes after the wrap point. A walker that compared against the wrong index would run past the last entry or return to 0 one slot early, and the entry-by-entry sequence check would catch either. It rewrites the last index in the middle of a walk. A design that restarted on every write of the control word would jump back to entry 0 while a slot was still held. It sends a stray done pulse in the gap between slots; a walker that counted it would skip an entry. It also disables the scheduler with a slot outstanding and then re-enables it. A design that kept its old index would resume mid-table, and one that cleared the table would present the wrong channels.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int DATA_W   = 32;
  localparam int ENTRY_W  = 8;
  localparam int CHAN_W   = 7;
  localparam int EN_BIT   = 31;
  localparam int PER_WORD = DATA_W / ENTRY_W;

  typedef struct packed {
    logic              rx;
    logic [CHAN_W-1:0] chan;
  } slot_entry_t;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_FETCH,
    ST_LOAD,
    ST_HOLD
  } walk_state_e;
endpackage

// File: rtl/dma_sched_table_ram.sv
module dma_sched_table_ram #(
  parameter int WORDS = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] mem [WORDS];

  // Read-first synchronous RAM; port A feeds the walker, port B the readback.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_a_data <= mem[rd_a_addr];
    rd_b_data <= mem[rd_b_addr];
  end
endmodule

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WORD_AW = 5,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               tbl_we,
  output logic [WORD_AW-1:0] tbl_addr,
  output logic [DATA_W-1:0]  tbl_wdata,
  input  logic [DATA_W-1:0]  tbl_rdata,
  output logic               sched_en,
  output logic [IDX_W-1:0]   last_idx
);
  logic hit_ctrl, hit_tbl;
  logic [1:0] rsel_q;
  logic [DATA_W-1:0] ctrl_snap_q;
  logic [DATA_W-1:0] ctrl_word;
  logic unused_wbits;

  assign hit_ctrl = (reg_addr == '0);
  assign hit_tbl  = reg_addr[ADDR_W-1] &&
                    (reg_addr[ADDR_W-2:WORD_AW+2] == '0) &&
                    (reg_addr[1:0] == 2'b00);
  assign tbl_addr  = reg_addr[WORD_AW+1:2];
  assign tbl_we    = reg_wr && hit_tbl;
  assign tbl_wdata = reg_wdata;
  assign unused_wbits = ^reg_wdata[EN_BIT-1:IDX_W];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT] = sched_en;
    ctrl_word[IDX_W-1:0] = last_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sched_en    <= 1'b0;
      last_idx    <= '0;
      rsel_q      <= 2'b00;
      ctrl_snap_q <= '0;
    end else begin
      if (reg_wr && hit_ctrl) begin
        sched_en <= reg_wdata[EN_BIT];
        last_idx <= reg_wdata[IDX_W-1:0];
      end
      if (reg_rd) begin
        rsel_q      <= {hit_tbl, hit_ctrl};
        ctrl_snap_q <= ctrl_word;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      2'b01:   reg_rdata = ctrl_snap_q;
      2'b10:   reg_rdata = tbl_rdata;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_sched_walker.sv
module dma_sched_walker
  import dma_sched_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int WORD_AW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sched_en,
  input  logic [IDX_W-1:0]   last_idx,
  output logic [WORD_AW-1:0] tbl_raddr,
  input  logic [DATA_W-1:0]  tbl_rdata,
  output logic               slot_valid,
  output logic [CHAN_W-1:0]  slot_chan,
  output logic               slot_rx,
  input  logic               slot_done,
  input  logic               slot_skip
);
  walk_state_e state;
  logic [IDX_W-1:0] idx;
  slot_entry_t entry;

  assign tbl_raddr = idx[IDX_W-1:2];
  assign entry = slot_entry_t'(tbl_rdata[{idx[1:0], 3'b000} +: ENTRY_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      idx        <= '0;
      slot_valid <= 1'b0;
      slot_chan  <= '0;
      slot_rx    <= 1'b0;
    end else if (!sched_en) begin
      state      <= ST_OFF;
      idx        <= '0;
      slot_valid <= 1'b0;
    end else begin
      case (state)
        ST_OFF:   state <= ST_FETCH;
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          slot_chan  <= entry.chan;
          slot_rx    <= entry.rx;
          slot_valid <= 1'b1;
          state      <= ST_HOLD;
        end
        ST_HOLD: begin
          if (slot_done || slot_skip) begin
            slot_valid <= 1'b0;
            idx        <= (idx == last_idx) ? '0 : idx + 1'b1;
            state      <= ST_FETCH;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
  import dma_sched_pkg::*;
#(
  parameter int TABLE_WORDS = 32,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              slot_valid,
  output logic [6:0]        slot_chan,
  output logic              slot_rx,
  input  logic              slot_done,
  input  logic              slot_skip
);
  localparam int WORD_AW = $clog2(TABLE_WORDS);
  localparam int IDX_W   = WORD_AW + $clog2(PER_WORD);

  logic               tbl_we;
  logic [WORD_AW-1:0] tbl_addr, walk_raddr;
  logic [DATA_W-1:0]  tbl_wdata, walk_rdata, sw_rdata;
  logic               sched_en;
  logic [IDX_W-1:0]   last_idx;

  dma_sched_regs #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_rdata(sw_rdata), .sched_en(sched_en), .last_idx(last_idx)
  );

  dma_sched_table_ram #(.WORDS(TABLE_WORDS), .AW(WORD_AW), .DW(DATA_W)) ram_i (
    .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .rd_a_addr(walk_raddr), .rd_a_data(walk_rdata),
    .rd_b_addr(tbl_addr), .rd_b_data(sw_rdata)
  );

  dma_sched_walker #(.IDX_W(IDX_W), .WORD_AW(WORD_AW)) walk_i (
    .clk(clk), .rst(rst), .sched_en(sched_en), .last_idx(last_idx),
    .tbl_raddr(walk_raddr), .tbl_rdata(walk_rdata),
    .slot_valid(slot_valid), .slot_chan(slot_chan), .slot_rx(slot_rx),
    .slot_done(slot_done), .slot_skip(slot_skip)
  );
endmodule

// File: rtl/dma_slot_sched_chk.sv
module dma_slot_sched_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              slot_valid,
  input logic [6:0]        slot_chan,
  input logic              slot_rx,
  input logic              slot_done,
  input logic              slot_skip
);
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && $past(slot_valid)) |-> ($stable(slot_chan) && $stable(slot_rx)));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && (slot_done || slot_skip)) |=> !slot_valid);

  assert_gap_two_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_valid) |=> !slot_valid);

  assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && (reg_addr == '0) && !reg_wdata[31], 2) |-> !slot_valid);
endmodule

bind dma_slot_sched dma_slot_sched_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .slot_valid(slot_valid), .slot_chan(slot_chan),
  .slot_rx(slot_rx), .slot_done(slot_done), .slot_skip(slot_skip)
);

// File: tb/dma_slot_sched_tb.sv
module dma_slot_sched_tb_top;
  localparam int TABLE_WORDS = 32;
  localparam int ADDR_W = 12;
  localparam int ENTRIES = TABLE_WORDS * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic slot_valid, slot_rx;
  logic [6:0] slot_chan;
  logic slot_done = 1'b0, slot_skip = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] tbl_m [TABLE_WORDS];
  int last_m = 0;
  int exp_idx = 0;

  always #10 clk = ~clk;

  dma_slot_sched #(.TABLE_WORDS(TABLE_WORDS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_valid(slot_valid), .slot_chan(slot_chan), .slot_rx(slot_rx),
    .slot_done(slot_done), .slot_skip(slot_skip)
  );

  function automatic logic [7:0] entry_of(int idx);
    logic [31:0] w;
    w = tbl_m[idx / 4];
    return w[(idx % 4) * 8 +: 8];
  endfunction

  function automatic int next_of(int idx, int last);
    return (idx == last) ? 0 : (idx + 1) % ENTRIES;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(int addr, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(int addr, output logic [31:0] data);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ADDR_W'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  task automatic write_word(int w, logic [31:0] data);
    write_reg(32'h800 + 4 * w, data);
    tbl_m[w] = data;
  endtask

  // Enable from the stopped state and check the three-edge latency (R12).
  task automatic enable_from_off(int last);
    write_reg(0, 32'h8000_0000 | 32'(last));
    last_m = last;
    exp_idx = 0;
    check(slot_valid == 1'b0, "R12", "valid one edge after write", slot_valid, 0);
    @(negedge clk);
    check(slot_valid == 1'b0, "R12", "valid two edges after write", slot_valid, 0);
    @(negedge clk);
    check(slot_valid == 1'b0, "R12", "valid three edges minus one", slot_valid, 0);
    @(negedge clk);
    check(slot_valid == 1'b1, "R12", "valid on third edge after write", slot_valid, 1);
  endtask

  // Wait for a presented slot and compare against the model entry (R3, R4).
  task automatic wait_slot();
    logic [7:0] e;
    int guard = 0;
    while (!slot_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    e = entry_of(exp_idx);
    check(slot_valid == 1'b1, "R4", "slot presented", slot_valid, 1);
    check(slot_chan == e[6:0] && slot_rx == e[7], "R3",
          $sformatf("entry %0d decode", exp_idx), {slot_rx, slot_chan}, e);
  endtask

  // Hold, then acknowledge with done or skip (R5, R6); optional stray pulse (R11).
  task automatic ack_slot(bit use_skip, int hold, bit stray);
    logic [6:0] c0;
    logic r0;
    c0 = slot_chan; r0 = slot_rx;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(slot_valid && slot_chan == c0 && slot_rx == r0, "R5", "slot held",
            {slot_valid, slot_rx, slot_chan}, {1'b1, r0, c0});
    end
    if (use_skip) slot_skip = 1'b1; else slot_done = 1'b1;
    @(negedge clk);
    slot_skip = 1'b0; slot_done = 1'b0;
    exp_idx = next_of(exp_idx, last_m);
    check(slot_valid == 1'b0, "R6", "gap cycle 1", slot_valid, 0);
    @(negedge clk);
    check(slot_valid == 1'b0, "R6", "gap cycle 2", slot_valid, 0);
    if (stray) slot_done = 1'b1;
    @(negedge clk);
    slot_done = 1'b0;
    check(slot_valid == 1'b1, "R6", "next slot on third edge", slot_valid, 1);
  endtask

  task automatic serve(int n);
    for (int i = 0; i < n; i++) begin
      wait_slot();
      ack_slot(bit'($urandom % 2), int'($urandom % 3), ($urandom % 5) == 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int nl;
    int w;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(slot_valid == 1'b0, "R1", "slot_valid after reset", slot_valid, 0);
    check(reg_rdata == 32'h0, "R1", "rdata after reset", reg_rdata, 0);
    read_reg(0, rd);
    check(rd == 32'h0, "R1", "control after reset", rd, 0);

    // Paired-channel load in words 0..14, random words after.
    for (int i = 0; i < 15; i++) begin
      logic [7:0] c;
      c = 8'(2 * i);
      write_word(i, {8'h80 | (c + 8'd1), c + 8'd1, 8'h80 | c, c});
    end
    for (int i = 15; i < TABLE_WORDS; i++) write_word(i, $urandom);

    // R2: readback of table and control
    for (int i = 0; i < 4; i++) begin
      w = (i == 3) ? TABLE_WORDS - 1 : i * 7;
      read_reg(32'h800 + 4 * w, rd);
      check(rd == tbl_m[w], "R2", $sformatf("table word %0d", w), rd, tbl_m[w]);
    end

    // R12, R4: enable over 60 paired entries and run past the wrap.
    enable_from_off(59);
    read_reg(0, rd);
    check(rd == 32'h8000_003B, "R2", "control readback", rd, 32'h8000_003B);
    serve(70);

    // R9: rewrite last index while a slot is held; no restart.
    wait_slot();
    nl = exp_idx + 2 + int'($urandom % 4);
    write_reg(0, 32'h8000_0000 | 32'(nl));
    check(slot_valid == 1'b1, "R9", "slot still held after ctrl write", slot_valid, 1);
    last_m = nl;
    ack_slot(1'b0, 0, 1'b0);
    serve(2 * (nl + 1) + 3);

    // R10: rewrite a table word while running.
    for (int k = 0; k < 3; k++) begin
      wait_slot();
      w = int'($urandom % ((last_m / 4) + 1));
      write_word(w, $urandom);
      ack_slot(1'b1, 1, 1'b0);
      serve(last_m + 2);
    end

    // R7: stop while a slot is held; table kept.
    wait_slot();
    write_reg(0, 32'h0);
    @(negedge clk);
    check(slot_valid == 1'b0, "R7", "valid dropped after stop", slot_valid, 0);
    for (int i = 0; i < 3; i++) begin
      w = int'($urandom % TABLE_WORDS);
      read_reg(32'h800 + 4 * w, rd);
      check(rd == tbl_m[w], "R7", $sformatf("table word %0d kept", w), rd, tbl_m[w]);
    end
    // R11: pulses while stopped change nothing
    slot_done = 1'b1; @(negedge clk); slot_done = 1'b0;
    check(slot_valid == 1'b0, "R11", "no slot while stopped", slot_valid, 0);

    // R8: re-enable restarts at entry 0 with a random table and last index.
    for (int i = 0; i < TABLE_WORDS; i++) write_word(i, $urandom);
    nl = 8 + int'($urandom % 33);
    enable_from_off(nl);
    check(exp_idx == 0, "R8", "model restart index", exp_idx, 0);
    wait_slot();
    ack_slot(1'b0, 0, 1'b0);
    serve(2 * (nl + 1) + 2);

    // R8: second stop/restart in mid-walk, then a short last index.
    write_reg(0, 32'h0);
    @(negedge clk);
    check(slot_valid == 1'b0, "R7", "valid dropped on second stop", slot_valid, 0);
    enable_from_off(3);
    serve(14);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule